// File: doc/BRIEF.md
# Asynchronous Serial Channel with Bit-Rate Clock Output

The channel moves 8-bit characters over a two-wire asynchronous link: a serial output `ser_tx` and a serial input `ser_rx`. A character on the wire is a low start bit, the data bits with the least significant bit first, an optional parity bit (even or odd), and one or two high stop bits. All bit timing comes from a tick at 16 times the bit rate. That tick is made either by an internal divider of the system clock or from an external clock fed in on `bclk_in`. When the internal divider is in use, the channel can also drive `bclk_out` at the bit rate. The rising edge of `bclk_out` falls at the middle of every transmitted bit.

Software-style control is kept to a few ports. The frame format and clock source are loaded with `cfg_wr`, and only while both enables are low. The transmitter has a one-character holding register and a `tx_empty` flag. The receiver has a data register and four flags: data-full, parity error, framing error and overrun. Dropping `tx_en` aborts the transmitter. Dropping `rx_en` stops reception but leaves the received data and every receive flag untouched.

Transmitter states: `TX_IDLE`, `TX_START`, `TX_DATA`, `TX_PAR`, `TX_STOP`. All moves happen at the end of a bit period, when the tick arrives while the phase counter is at 15:
- `TX_IDLE` goes to `TX_START` when the holding register is full.
- `TX_START` goes to `TX_DATA`.
- `TX_DATA` goes to `TX_PAR` or `TX_STOP` after the eighth bit.
- `TX_PAR` goes to `TX_STOP`.
- `TX_STOP` goes to `TX_START` for back-to-back characters when the holding register is full, or otherwise to `TX_IDLE` once the last stop bit ends.

Receiver states: `RX_IDLE`, `RX_START`, `RX_DATA`, `RX_PAR`, `RX_STOP`:
- `RX_IDLE` goes to `RX_START` on a high-to-low edge of the line.
- `RX_START` goes to `RX_DATA` if the line is still low 8 ticks later, and back to `RX_IDLE` if it is high.
- `RX_DATA` samples every 16 ticks and leaves after eight bits, to `RX_PAR` or `RX_STOP`.
- `RX_PAR` goes to `RX_STOP`.
- `RX_STOP` goes to `RX_IDLE` after the stop sample, posting the character.

Clearing either enable sends its machine straight to idle.

Top module: `async_serial_channel`

## Requirements
- R1: After reset `tx_empty` is 1, `rx_full`, `par_err`, `frm_err` and `ovr_err` are 0, `ser_tx` is 1 and `bclk_oe` is 0.
- R2: A character written to the transmitter is received unchanged when `ser_tx` is looped to `ser_rx`. The frame is a 0 start bit, then data with LSB first, then stop bits of 1.
- R3: With `cfg_par_en`=1, a parity bit follows the data. With `cfg_par_odd`=0 the data plus parity bit hold an even count of ones; with 1 they hold an odd count. A received parity bit that breaks this rule sets `par_err`.
- R4: With the internal source, every bit on `ser_tx` lasts 16*(`cfg_div`+1) system clocks.
- R5: `cfg_clk_sel` selects the clock source: 0 is internal with the pin unused, 1 is internal with the pin driven, and 2 or 3 is external. `bclk_oe` is 1 only for select value 1. In that mode the first rising edge of `bclk_out` after the start bit begins comes 8 ticks later.
- R6: With the external source, each rising edge of `bclk_in` is one tick, so a bit lasts 16 `bclk_in` periods.
- R7: A write to the transmit holding register clears `tx_empty`. The flag returns to 1 when the character moves into the shift register at the start of its frame.
- R8: While `tx_en` is 0, `ser_tx` is 1, `tx_empty` is 1, a frame in progress is abandoned and writes to the holding register are ignored.
- R9: While `rx_en` is 0, `rx_data`, `rx_full`, `par_err`, `frm_err` and `ovr_err` keep their values, and frames on `ser_rx` are ignored.
- R10: `cfg_wr` is ignored while `tx_en` or `rx_en` is 1.
- R11: A low pulse on `ser_rx` that has ended by the check 8 ticks after the falling edge is discarded without posting a character.
- R12: A stop bit sampled as 0 sets `frm_err` while the character is still posted to `rx_data`.
- R13: A character that completes while `rx_full` is 1 sets `ovr_err` and leaves `rx_data` holding the older character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load the format and clock-source fields |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_two_stop | input | 1 | Transmit two stop bits |
| cfg_clk_sel | input | 2 | 0 internal, 1 internal with pin output, 2/3 external |
| cfg_div | input | 8 | Internal divider: tick every cfg_div+1 clocks |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tx_data_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Character to transmit |
| rx_data_rd | input | 1 | Read strobe: clears rx_full |
| err_clr | input | 1 | Clears par_err, frm_err and ovr_err |
| ser_rx | input | 1 | Serial receive line |
| bclk_in | input | 1 | External clock at 16x the bit rate |
| ser_tx | output | 1 | Serial transmit line |
| tx_empty | output | 1 | Transmit holding register empty |
| rx_data | output | 8 | Last character received |
| rx_full | output | 1 | Received character waiting |
| par_err | output | 1 | Parity error flag |
| frm_err | output | 1 | Framing error flag |
| ovr_err | output | 1 | Overrun flag |
| bclk_out | output | 1 | Bit-rate clock output |
| bclk_oe | output | 1 | Output enable for bclk_out |

## Verification
The hardest case to reach from the ports is a receiver switched off while it holds a full, overrun character. The only way to get there is to send two complete frames without reading, then drop `rx_en` and push a third frame onto the line. To bring this about, the bench stops looping `ser_tx` back and drives `ser_rx` bit by bit at the divider's bit time. With the same direct line control it also builds frames with a wrong parity bit, a zero stop bit, and a start pulse too short to pass the mid-bit check. Mid-frame transmitter abort and the placement of the output clock edge are reached by counting clock cycles from the falling edge of `ser_tx`.

// File: rtl/asc_pkg.sv
package asc_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PAR,
        TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef enum logic [1:0] {
        CLK_INT     = 2'b00,
        CLK_INT_OUT = 2'b01,
        CLK_EXT     = 2'b10
    } clk_src_e;

endpackage

// File: rtl/asc_tick_gen.sv
module asc_tick_gen #(
    parameter int DIV_W = 8,
    parameter int OSR   = 16,
    localparam int PH_W = $clog2(OSR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_sel,
    input  logic [DIV_W-1:0] div,
    input  logic             ext_clk,
    output logic             tick,
    output logic [PH_W-1:0]  phase
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);

    logic [2:0]       ext_sync;
    logic [DIV_W-1:0] cnt;
    logic             int_tick;
    logic             ext_tick;

    assign int_tick = (cnt == div);
    assign ext_tick = ext_sync[1] & ~ext_sync[2];
    assign tick     = ext_sel ? ext_tick : int_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_sync <= '0;
            cnt      <= '0;
            phase    <= '0;
        end else begin
            ext_sync <= {ext_sync[1:0], ext_clk};
            cnt      <= int_tick ? '0 : cnt + 1'b1;
            if (tick)
                phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        end
    end

    // R4: internal ticks are spaced by div+1 clocks, never adjacent for div>0
    p_int_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_sel && tick && div != '0) |=> (ext_sel || !$stable(div) || !tick));

    // R6: an external tick needs a rising edge seen through the synchroniser
    p_ext_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel && tick) |=> !tick || !ext_sel);

endmodule

// File: rtl/asc_tx.sv
module asc_tx
    import asc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    localparam int PH_W  = $clog2(OSR),
    localparam int BC_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic [PH_W-1:0]   phase,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              txd,
    output logic              empty
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(DATA_W - 1);

    tx_state_e         st, st_nx;
    logic [DATA_W-1:0] hold;
    logic [DATA_W-1:0] shreg;
    logic [BC_W-1:0]   bcnt;
    logic              par_bit;
    logic              stop_more;
    logic              bit_end;
    logic              load;

    assign bit_end = tick && (phase == PH_LAST);
    assign load    = en && bit_end && !empty &&
                     (st == TX_IDLE || (st == TX_STOP && !stop_more));

    always_comb begin
        st_nx = st;
        unique case (st)
            TX_IDLE:  if (load) st_nx = TX_START;
            TX_START: if (bit_end) st_nx = TX_DATA;
            TX_DATA:  if (bit_end && bcnt == BC_LAST) st_nx = par_en ? TX_PAR : TX_STOP;
            TX_PAR:   if (bit_end) st_nx = TX_STOP;
            TX_STOP:  if (bit_end && !stop_more) st_nx = load ? TX_START : TX_IDLE;
            default:  st_nx = TX_IDLE;
        endcase
        if (!en)
            st_nx = TX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= TX_IDLE;
        else
            st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold      <= '0;
            shreg     <= '0;
            bcnt      <= '0;
            par_bit   <= 1'b0;
            stop_more <= 1'b0;
            empty     <= 1'b1;
        end else if (!en) begin
            empty     <= 1'b1;
            stop_more <= 1'b0;
        end else begin
            if (st == TX_DATA && bit_end) begin
                shreg <= shreg >> 1;
                bcnt  <= bcnt + 1'b1;
                if (bcnt == BC_LAST)
                    stop_more <= two_stop;
            end
            if (st == TX_STOP && bit_end && stop_more)
                stop_more <= 1'b0;
            if (load) begin
                shreg   <= hold;
                par_bit <= (^hold) ^ par_odd;
                bcnt    <= '0;
                empty   <= 1'b1;
            end
            if (wr) begin
                hold  <= wdata;
                empty <= 1'b0;
            end
        end
    end

    always_comb begin
        txd = 1'b1;
        unique case (st)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            TX_PAR:   txd = par_bit;
            TX_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end

    // R8: a disabled transmitter idles high and reports empty
    p_off_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (txd && empty));

    // R7: a write while enabled always leaves the holding register full
    p_wr_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr) |=> !empty);

    // R2: a frame only starts on a bit boundary
    p_start_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st != TX_START && st_nx == TX_START) |-> bit_end);

endmodule

// File: rtl/asc_rx.sv
module asc_rx
    import asc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    localparam int SC_W  = $clog2(OSR),
    localparam int BC_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              line,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rd,
    input  logic              clr,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              par_err,
    output logic              frm_err,
    output logic              ovr_err
);

    localparam logic [SC_W-1:0] SC_HALF = SC_W'(OSR / 2 - 1);
    localparam logic [SC_W-1:0] SC_LAST = SC_W'(OSR - 1);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(DATA_W - 1);

    rx_state_e         st, st_nx;
    logic [2:0]        sy;
    logic              s_line;
    logic              fall;
    logic [SC_W-1:0]   sub;
    logic [BC_W-1:0]   bcnt;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              samp_mid;
    logic              samp_full;
    logic              done;

    assign s_line    = sy[1];
    assign fall      = sy[2] & ~sy[1];
    assign samp_mid  = tick && (sub == SC_HALF);
    assign samp_full = tick && (sub == SC_LAST);
    assign done      = en && (st == RX_STOP) && samp_full;

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_IDLE:  if (fall) st_nx = RX_START;
            RX_START: if (samp_mid) st_nx = s_line ? RX_IDLE : RX_DATA;
            RX_DATA:  if (samp_full && bcnt == BC_LAST) st_nx = par_en ? RX_PAR : RX_STOP;
            RX_PAR:   if (samp_full) st_nx = RX_STOP;
            RX_STOP:  if (samp_full) st_nx = RX_IDLE;
            default:  st_nx = RX_IDLE;
        endcase
        if (!en)
            st_nx = RX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= RX_IDLE;
        else
            st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy      <= '1;
            sub     <= '0;
            bcnt    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
        end else begin
            sy <= {sy[1:0], line};
            if (st != st_nx)
                sub <= '0;
            else if (tick)
                sub <= (sub == SC_LAST) ? '0 : sub + 1'b1;
            if (st == RX_START)
                bcnt <= '0;
            if (st == RX_DATA && samp_full) begin
                shreg <= {s_line, shreg[DATA_W-1:1]};
                bcnt  <= bcnt + 1'b1;
            end
            if (st == RX_PAR && samp_full)
                par_bit <= s_line;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data    <= '0;
            full    <= 1'b0;
            par_err <= 1'b0;
            frm_err <= 1'b0;
            ovr_err <= 1'b0;
        end else begin
            if (rd)
                full <= 1'b0;
            if (clr) begin
                par_err <= 1'b0;
                frm_err <= 1'b0;
                ovr_err <= 1'b0;
            end
            if (done) begin
                if (full && !rd) begin
                    ovr_err <= 1'b1;
                end else begin
                    data    <= shreg;
                    full    <= 1'b1;
                    frm_err <= ~s_line;
                    par_err <= par_en & ((^shreg) ^ par_bit ^ par_odd);
                end
            end
        end
    end

    // R9: a disabled receiver leaves data and flags alone
    p_off_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !rd && !clr) |=> ($stable(full) && $stable(data) && $stable(par_err)
                                  && $stable(frm_err) && $stable(ovr_err)));

    // R9: a character is posted only while the receiver is enabled
    p_post_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(en));

    // R13: an overrun keeps the older character and its full flag
    p_ovr_keep_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_err) |-> ($stable(data) && full));

endmodule

// File: rtl/async_serial_channel.sv
module async_serial_channel
    import asc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int OSR    = 16,
    localparam int PH_W  = $clog2(OSR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic [1:0]        cfg_clk_sel,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              tx_data_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_data_rd,
    input  logic              err_clr,
    input  logic              ser_rx,
    input  logic              bclk_in,
    output logic              ser_tx,
    output logic              tx_empty,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              par_err,
    output logic              frm_err,
    output logic              ovr_err,
    output logic              bclk_out,
    output logic              bclk_oe
);

    clk_src_e         c_src;
    logic             c_par_en;
    logic             c_par_odd;
    logic             c_two_stop;
    logic [DIV_W-1:0] c_div;
    logic             tick;
    logic [PH_W-1:0]  phase;
    logic             cfg_open;

    assign cfg_open = !tx_en && !rx_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_src      <= CLK_INT;
            c_par_en   <= 1'b0;
            c_par_odd  <= 1'b0;
            c_two_stop <= 1'b0;
            c_div      <= '0;
        end else if (cfg_wr && cfg_open) begin
            c_src      <= cfg_clk_sel[1] ? CLK_EXT : (cfg_clk_sel[0] ? CLK_INT_OUT : CLK_INT);
            c_par_en   <= cfg_par_en;
            c_par_odd  <= cfg_par_odd;
            c_two_stop <= cfg_two_stop;
            c_div      <= cfg_div;
        end
    end

    asc_tick_gen #(.DIV_W(DIV_W), .OSR(OSR)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_sel (c_src == CLK_EXT),
        .div     (c_div),
        .ext_clk (bclk_in),
        .tick    (tick),
        .phase   (phase)
    );

    asc_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (tx_en),
        .tick     (tick),
        .phase    (phase),
        .par_en   (c_par_en),
        .par_odd  (c_par_odd),
        .two_stop (c_two_stop),
        .wr       (tx_data_wr),
        .wdata    (tx_data),
        .txd      (ser_tx),
        .empty    (tx_empty)
    );

    asc_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rx_en),
        .tick    (tick),
        .line    (ser_rx),
        .par_en  (c_par_en),
        .par_odd (c_par_odd),
        .rd      (rx_data_rd),
        .clr     (err_clr),
        .data    (rx_data),
        .full    (rx_full),
        .par_err (par_err),
        .frm_err (frm_err),
        .ovr_err (ovr_err)
    );

    assign bclk_oe  = (c_src == CLK_INT_OUT);
    assign bclk_out = bclk_oe & phase[PH_W-1];

    // R10: settings stay frozen while either direction is enabled
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en || rx_en) |=> ($stable(c_src) && $stable(c_div) && $stable(c_par_en)
                              && $stable(c_par_odd) && $stable(c_two_stop)));

    // R5: the clock pin is never driven while the external source is chosen
    p_oe_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_src == CLK_EXT) |-> !bclk_out);

endmodule

// File: tb/async_serial_channel_bench.sv
module async_serial_channel_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 3;
    localparam int BT         = 16 * (DIV + 1);
    localparam int EXT_HALF   = 4;
    localparam int EBT        = 16 * 2 * EXT_HALF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic [1:0] cfg_clk_sel = 2'b00;
    logic [7:0] cfg_div = 8'd0;
    logic       tx_en = 1'b0, rx_en = 1'b0;
    logic       tx_data_wr = 1'b0;
    logic [7:0] tx_data = 8'd0;
    logic       mon_rd = 1'b0, t_rd = 1'b0;
    logic       err_clr = 1'b0;
    logic       loop = 1'b0, raw_rxd = 1'b1;
    logic       bclk_in = 1'b0, ext_on = 1'b0;
    logic       mon_on = 1'b0;
    logic       ser_rx, ser_tx, tx_empty, rx_full, par_err, frm_err, ovr_err, bclk_out, bclk_oe;
    logic [7:0] rx_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];

    assign ser_rx = loop ? ser_tx : raw_rxd;

    always #(CLK_PERIOD / 2) clk = ~clk;

    async_serial_channel u_async_serial_channel (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop), .cfg_clk_sel(cfg_clk_sel),
        .cfg_div(cfg_div), .tx_en(tx_en), .rx_en(rx_en), .tx_data_wr(tx_data_wr),
        .tx_data(tx_data), .rx_data_rd(mon_rd | t_rd), .err_clr(err_clr), .ser_rx(ser_rx),
        .bclk_in(bclk_in), .ser_tx(ser_tx), .tx_empty(tx_empty), .rx_data(rx_data),
        .rx_full(rx_full), .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err),
        .bclk_out(bclk_out), .bclk_oe(bclk_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic set_cfg(input logic [1:0] sel, input logic pe, input logic po,
                           input logic two, input logic [7:0] dv);
        cfg_clk_sel = sel; cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = two; cfg_div = dv;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_hold(input logic [7:0] b);
        tx_data = b; tx_data_wr = 1'b1;
        @(negedge clk);
        tx_data_wr = 1'b0;
    endtask

    // scoreboard driver: queue the expectation, then hand the byte over
    task automatic send_byte(input logic [7:0] b);
        while (!tx_empty) @(negedge clk);
        exp_q.push_back(b);
        wr_hold(b);
    endtask

    task automatic pulse_rd_clr();
        t_rd = 1'b1; err_clr = 1'b1;
        @(negedge clk);
        t_rd = 1'b0; err_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_raw(input logic [7:0] b, input logic has_par,
                            input logic pbit, input logic stopb);
        raw_rxd = 1'b0;
        repeat (BT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            raw_rxd = b[i];
            repeat (BT) @(negedge clk);
        end
        if (has_par) begin
            raw_rxd = pbit;
            repeat (BT) @(negedge clk);
        end
        raw_rxd = stopb;
        repeat (BT) @(negedge clk);
        raw_rxd = 1'b1;
        repeat (BT) @(negedge clk);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic meas_low(output int w);
        while (ser_tx) @(negedge clk);
        w = 0;
        while (!ser_tx) begin
            w++;
            @(negedge clk);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on && rx_full && !mon_rd) begin
                if (exp_q.size() == 0) begin
                    chk("R2 unexpected character", rx_data, 'hFFFF);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk("R2 loopback data", rx_data, e);
                    chk("R3 loopback par_err", par_err, 0);
                    chk("R12 loopback frm_err", frm_err, 0);
                end
                mon_rd = 1'b1;
            end else begin
                mon_rd = 1'b0;
            end
        end
    end

    initial begin
        forever begin
            repeat (EXT_HALF) @(negedge clk);
            if (ext_on) bclk_in = ~bclk_in;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 errors", {par_err, frm_err, ovr_err}, 0);
        chk("R1 ser_tx", ser_tx, 1);
        chk("R1 bclk_oe", bclk_oe, 0);

        set_cfg(2'b01, 1'b0, 1'b0, 1'b0, 8'(DIV));
        loop = 1'b1; mon_on = 1'b1; tx_en = 1'b1; rx_en = 1'b1;
        @(negedge clk);
        // R10: ignored while enabled
        set_cfg(2'b00, 1'b1, 1'b1, 1'b1, 8'd7);
        chk("R10 bclk_oe kept", bclk_oe, 1);
        chk("R5 bclk_oe internal out", bclk_oe, 1);

        // R5: clock edge in the middle of the start bit
        send_byte(8'hFF);
        while (ser_tx) @(negedge clk);
        w = 0;
        while (!bclk_out) begin
            @(negedge clk);
            w++;
        end
        chk("R5 rise at mid-bit", (w >= 8 * (DIV + 1) - 1 && w <= 8 * (DIV + 1) + 1), 1);
        // R7: write while busy clears empty
        send_byte(8'hFF);
        chk("R7 empty after write", tx_empty, 0);
        while (!ser_tx) @(negedge clk);
        meas_low(w);
        chk("R4 bit time", w, BT);
        chk("R7 empty after load", tx_empty, 1);
        send_byte(8'h00);
        send_byte(8'hA5);
        send_byte(8'h3C);
        drain();

        // R3 even then odd parity with two stop bits
        tx_en = 1'b0; rx_en = 1'b0;
        set_cfg(2'b00, 1'b1, 1'b0, 1'b0, 8'(DIV));
        tx_en = 1'b1; rx_en = 1'b1;
        send_byte(8'h5A); send_byte(8'h01); send_byte(8'h7F);
        drain();
        tx_en = 1'b0; rx_en = 1'b0;
        set_cfg(2'b00, 1'b1, 1'b1, 1'b1, 8'(DIV));
        tx_en = 1'b1; rx_en = 1'b1;
        send_byte(8'h80); send_byte(8'hE7);
        drain();

        // direct line tests, even parity
        tx_en = 1'b0; rx_en = 1'b0; mon_on = 1'b0; loop = 1'b0;
        set_cfg(2'b00, 1'b1, 1'b0, 1'b0, 8'(DIV));
        rx_en = 1'b1;
        @(negedge clk);
        send_raw(8'h35, 1'b1, 1'b1, 1'b1);
        chk("R3 par_err set", par_err, 1);
        chk("R3 rx_full", rx_full, 1);
        chk("R3 data", rx_data, 8'h35);
        pulse_rd_clr();
        chk("R3 par_err cleared", par_err, 0);

        send_raw(8'h81, 1'b1, 1'b0, 1'b0);
        chk("R12 frm_err", frm_err, 1);
        chk("R12 par_err clean", par_err, 0);
        chk("R12 data posted", rx_data, 8'h81);
        pulse_rd_clr();

        send_raw(8'h11, 1'b1, 1'b0, 1'b1);
        send_raw(8'h22, 1'b1, 1'b0, 1'b1);
        chk("R13 ovr_err", ovr_err, 1);
        chk("R13 old data kept", rx_data, 8'h11);

        // R9: receiver off keeps everything
        rx_en = 1'b0;
        send_raw(8'h44, 1'b1, 1'b0, 1'b1);
        chk("R9 rx_full kept", rx_full, 1);
        chk("R9 ovr_err kept", ovr_err, 1);
        chk("R9 data kept", rx_data, 8'h11);
        rx_en = 1'b1;
        pulse_rd_clr();
        chk("R9 flags clear after enable", {rx_full, ovr_err}, 0);

        // R11: short low pulse is discarded
        raw_rxd = 1'b0;
        repeat (3 * (DIV + 1)) @(negedge clk);
        raw_rxd = 1'b1;
        repeat (3 * BT) @(negedge clk);
        chk("R11 glitch ignored", rx_full, 0);
        send_raw(8'h6B, 1'b1, 1'b1, 1'b1);
        chk("R11 next frame data", rx_data, 8'h6B);
        chk("R11 next frame full", rx_full, 1);
        pulse_rd_clr();

        // R8: transmitter abort
        tx_en = 1'b1;
        @(negedge clk);
        wr_hold(8'h00);
        while (ser_tx) @(negedge clk);
        repeat (100) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk("R8 line high", ser_tx, 1);
        chk("R8 empty", tx_empty, 1);
        wr_hold(8'h12);
        chk("R8 write ignored", tx_empty, 1);
        repeat (2 * BT) @(negedge clk);
        chk("R8 line stays high", ser_tx, 1);

        // R6: external clock source
        rx_en = 1'b0;
        set_cfg(2'b10, 1'b0, 1'b0, 1'b0, 8'(DIV));
        ext_on = 1'b1; loop = 1'b1; mon_on = 1'b1; tx_en = 1'b1; rx_en = 1'b1;
        repeat (4) @(negedge clk);
        chk("R5 bclk_oe external", bclk_oe, 0);
        send_byte(8'hFF);
        meas_low(w);
        chk("R6 bit time", w, EBT);
        send_byte(8'hC6);
        send_byte(8'h39);
        drain();

        summary();
    end

endmodule